// File: doc/BRIEF.md
# Bus Status Decoder and Command Generator

This block sits beside a processor whose bus cycles are announced only through a 3-bit status code. It samples that code on every clock and finds the start of each bus cycle itself, with no separate start signal. A cycle starts when the code leaves the all-ones passive value, and it ends when the code returns to passive while READY is high. For each cycle it produces a one-clock address-latch pulse, the command strobe that belongs to the decoded cycle type, a data-transceiver enable and a transceiver direction line. Every output is active high.

The status and READY inputs are registered once before any decision is taken. A sequencer walks through the named states ST_IDLE, ST_ADDR, ST_SETUP, ST_CMD and ST_HALT, and a separate output decoder turns the state and the latched cycle type into strobes.

The transitions are as follows. START goes from ST_IDLE to ST_ADDR when the registered code is non-passive and the code registered one clock earlier was passive. From ST_ADDR, the next state is ST_HALT for a halt, ST_SETUP for a write and ST_CMD for any other type. SETUP_DONE goes from ST_SETUP to ST_CMD. FINISH goes from ST_ADDR, ST_SETUP, ST_CMD or ST_HALT back to ST_IDLE when the registered code is passive and the registered READY is high. The cycle type is latched on START, and later status changes do not alter it.

Top module: `bus_cmd_gen`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, all outputs are low. A reset in the middle of a cycle ends that cycle.
- R2: If `stat` is non-passive on clock edge k, was passive on edge k-1, and the block is idle, then `ale` is high for exactly one clock, after edge k+1. No command and no `den` go high in that clock.
- R3: The cycle type is decoded from the first non-passive code as follows. 000 is interrupt acknowledge and drives `int_ack`. 001 is an I/O read and drives `io_rd`. 010 is an I/O write and drives `io_wr`. 011 is halt. 100 (code fetch) and 101 (memory read) both drive `mem_rd`. 110 is a memory write and drives `mem_wr`. 111 is passive.
- R4: For a write, `den` and `dt_tx` go high after edge k+2, and the write strobe joins them after edge k+3. All three stay high until the cycle ends.
- R5: For a read type or an acknowledge, the strobe and `den` go high together after edge k+2, and `dt_tx` stays low.
- R6: A halt cycle gives the `ale` pulse and then no command strobe and no `den` for its whole length.
- R7: If passive is sampled with `rdy` high on edge m, then all outputs are low after edge m+1.
- R8: While `rdy` is sampled low, a passive code does not end the cycle, and the strobes stay high.
- R9: Non-passive codes that change in the middle of a cycle do not alter the cycle type or the strobes.
- R10: At most one of the five command strobes is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stat | input | 3 | Processor bus status code (111 = passive) |
| rdy | input | 1 | Transfer-complete acknowledge from the addressed device |
| ale | output | 1 | Address latch pulse |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| int_ack | output | 1 | Interrupt acknowledge command |
| den | output | 1 | Data transceiver enable |
| dt_tx | output | 1 | Transceiver direction, high = toward the bus |

## Verification
The hardest situation to reach is a cycle that is held open while the status has already gone passive but `rdy` is still low. The same applies to a cycle whose status wanders through other non-passive codes before it ends. The stimulus builds each cycle from random pieces: an active length (which may be one clock), a run of changing non-passive codes, and a number of passive clocks with `rdy` low. This reaches the short-cycle boundaries, where FINISH falls in ST_ADDR or ST_SETUP, as well as long held cycles. Directed cases cover a one-clock cycle, a write that ends straight after its setup clock, and a reset that arrives during a command.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETUP,
        ST_CMD,
        ST_HALT
    } bus_state_t;

    typedef enum logic [2:0] {
        K_INTA,
        K_IORD,
        K_IOWR,
        K_HALT,
        K_MRD,
        K_MWR,
        K_NONE
    } cyc_kind_t;

    typedef struct packed {
        logic ale;
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
        logic int_ack;
        logic den;
        logic dt_tx;
    } cmd_bus_t;

    function automatic cyc_kind_t decode_kind(input logic [2:0] code);
        cyc_kind_t k;
        unique case (code)
            3'b000:  k = K_INTA;
            3'b001:  k = K_IORD;
            3'b010:  k = K_IOWR;
            3'b011:  k = K_HALT;
            3'b100:  k = K_MRD;
            3'b101:  k = K_MRD;
            3'b110:  k = K_MWR;
            default: k = K_NONE;
        endcase
        return k;
    endfunction

    function automatic logic kind_is_write(input cyc_kind_t k);
        return (k == K_IOWR) || (k == K_MWR);
    endfunction

endpackage

// File: rtl/bsd_sample.sv
module bsd_sample #(
    parameter int STAT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat,
    input  logic              rdy,
    output logic [STAT_W-1:0] stat_q,
    output logic              passive_now,
    output logic              passive_prev,
    output logic              rdy_q
);
    localparam logic [STAT_W-1:0] PASSIVE = '1;

    logic [STAT_W-1:0] stat_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= PASSIVE;
            stat_p <= PASSIVE;
            rdy_q  <= 1'b1;
        end else begin
            stat_q <= stat;
            stat_p <= stat_q;
            rdy_q  <= rdy;
        end
    end

    always_comb begin
        passive_now  = (stat_q == PASSIVE);
        passive_prev = (stat_p == PASSIVE);
    end

endmodule

// File: rtl/bsd_seq.sv
module bsd_seq
    import bsd_pkg::*;
#(
    parameter int STAT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat_q,
    input  logic              passive_now,
    input  logic              passive_prev,
    input  logic              rdy_q,
    output bus_state_t        state,
    output cyc_kind_t         kind
);
    bus_state_t state_nx;
    cyc_kind_t  kind_nx;
    logic       start_hit;
    logic       finish_hit;

    always_comb begin
        start_hit  = (state == ST_IDLE) && !passive_now && passive_prev;
        finish_hit = passive_now && rdy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            kind  <= K_NONE;
        end else begin
            state <= state_nx;
            kind  <= kind_nx;
        end
    end

    always_comb begin
        state_nx = state;
        kind_nx  = kind;
        unique case (state)
            ST_IDLE: begin
                if (start_hit) begin
                    state_nx = ST_ADDR;
                    kind_nx  = decode_kind(stat_q[2:0]);
                end
            end
            ST_ADDR: begin
                if (finish_hit)
                    state_nx = ST_IDLE;
                else if (kind == K_HALT)
                    state_nx = ST_HALT;
                else if (kind_is_write(kind))
                    state_nx = ST_SETUP;
                else
                    state_nx = ST_CMD;
            end
            ST_SETUP: begin
                state_nx = finish_hit ? ST_IDLE : ST_CMD;
            end
            ST_CMD: begin
                if (finish_hit)
                    state_nx = ST_IDLE;
            end
            ST_HALT: begin
                if (finish_hit)
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/bsd_drive.sv
module bsd_drive
    import bsd_pkg::*;
(
    input  bus_state_t state,
    input  cyc_kind_t  kind,
    output cmd_bus_t   cmd
);
    always_comb begin
        cmd = '0;
        unique case (state)
            ST_IDLE: cmd = '0;
            ST_ADDR: cmd.ale = 1'b1;
            ST_SETUP: begin
                cmd.den   = 1'b1;
                cmd.dt_tx = 1'b1;
            end
            ST_CMD: begin
                unique case (kind)
                    K_INTA: begin
                        cmd.int_ack = 1'b1;
                        cmd.den     = 1'b1;
                    end
                    K_IORD: begin
                        cmd.io_rd = 1'b1;
                        cmd.den   = 1'b1;
                    end
                    K_MRD: begin
                        cmd.mem_rd = 1'b1;
                        cmd.den    = 1'b1;
                    end
                    K_IOWR: begin
                        cmd.io_wr = 1'b1;
                        cmd.den   = 1'b1;
                        cmd.dt_tx = 1'b1;
                    end
                    K_MWR: begin
                        cmd.mem_wr = 1'b1;
                        cmd.den    = 1'b1;
                        cmd.dt_tx  = 1'b1;
                    end
                    default: cmd = '0;
                endcase
            end
            ST_HALT: cmd = '0;
            default: cmd = '0;
        endcase
    end

endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
    import bsd_pkg::*;
#(
    parameter int STAT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat,
    input  logic              rdy,
    output logic              ale,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              int_ack,
    output logic              den,
    output logic              dt_tx
);
    logic [STAT_W-1:0] stat_q;
    logic              passive_now;
    logic              passive_prev;
    logic              rdy_q;
    bus_state_t        state;
    cyc_kind_t         kind;
    cmd_bus_t          cmd;

    bsd_sample #(.STAT_W(STAT_W)) u_sample (
        .clk         (clk),
        .rst         (rst),
        .stat        (stat),
        .rdy         (rdy),
        .stat_q      (stat_q),
        .passive_now (passive_now),
        .passive_prev(passive_prev),
        .rdy_q       (rdy_q)
    );

    bsd_seq #(.STAT_W(STAT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .stat_q      (stat_q),
        .passive_now (passive_now),
        .passive_prev(passive_prev),
        .rdy_q       (rdy_q),
        .state       (state),
        .kind        (kind)
    );

    bsd_drive u_drive (
        .state(state),
        .kind (kind),
        .cmd  (cmd)
    );

    always_comb begin
        ale     = cmd.ale;
        mem_rd  = cmd.mem_rd;
        mem_wr  = cmd.mem_wr;
        io_rd   = cmd.io_rd;
        io_wr   = cmd.io_wr;
        int_ack = cmd.int_ack;
        den     = cmd.den;
        dt_tx   = cmd.dt_tx;
    end

endmodule

// File: rtl/bsd_chk.sv
module bsd_chk (
    input logic clk,
    input logic rst,
    input logic ale,
    input logic mem_rd,
    input logic mem_wr,
    input logic io_rd,
    input logic io_wr,
    input logic int_ack,
    input logic den,
    input logic dt_tx
);
    logic any_cmd;
    logic any_wr;
    logic any_rd;
    always_comb begin
        any_wr  = mem_wr || io_wr;
        any_rd  = mem_rd || io_rd || int_ack;
        any_cmd = any_wr || any_rd;
    end

    // R10
    cmd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr, io_rd, io_wr, int_ack}));

    // R2
    ale_single_chk: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    // R2
    ale_alone_chk: assert property (@(posedge clk) disable iff (rst)
        ale |-> !any_cmd && !den);

    // R4
    wr_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(any_wr) |-> $past(den && dt_tx));

    // R4
    wr_dir_chk: assert property (@(posedge clk) disable iff (rst)
        any_wr |-> den && dt_tx);

    // R5
    rd_dir_chk: assert property (@(posedge clk) disable iff (rst)
        any_rd |-> den && !dt_tx);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !ale && !any_cmd && !den && !dt_tx);

endmodule

bind bus_cmd_gen bsd_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .ale    (ale),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .io_rd  (io_rd),
    .io_wr  (io_wr),
    .int_ack(int_ack),
    .den    (den),
    .dt_tx  (dt_tx)
);

// File: tb/sim_bus_cmd_gen.sv
`timescale 1ns/1ps
module sim_bus_cmd_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] stat = 3'b111;
    logic       rdy = 1'b1;
    logic ale, mem_rd, mem_wr, io_rd, io_wr, int_ack, den, dt_tx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_cmd_gen u0 (
        .clk(clk), .rst(rst), .stat(stat), .rdy(rdy),
        .ale(ale), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
        .io_wr(io_wr), .int_ack(int_ack), .den(den), .dt_tx(dt_tx)
    );

    // vector order: ale mem_rd mem_wr io_rd io_wr int_ack den dt_tx
    function automatic logic [7:0] exp_out(input logic [2:0] code, input int t, input int e);
        if (t < 2 || t >= e) return 8'b0;
        if (t == 2) return 8'b1000_0000;
        case (code)
            3'b000: return 8'b0000_0110;
            3'b001: return 8'b0001_0010;
            3'b010: return (t == 3) ? 8'b0000_0011 : 8'b0000_1011;
            3'b011: return 8'b0;
            3'b100, 3'b101: return 8'b0100_0010;
            3'b110: return (t == 3) ? 8'b0000_0011 : 8'b0010_0011;
            default: return 8'b0;
        endcase
    endfunction

    function automatic logic [7:0] obs();
        return {ale, mem_rd, mem_wr, io_rd, io_wr, int_ack, den, dt_tx};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b", tag, act, exp);
        end
        checks++;
        if ($countones(act[6:2]) > 1) begin
            errors++;
            $display("FAIL R10: strobes %b expected at most one", act[6:2]);
        end
    endtask

    // One bus cycle: n active clocks (glitching codes if glt), then w passive clocks with rdy low.
    task automatic run_cycle(input logic [2:0] code, input int n, input int w, input bit glt);
        int e;
        string tag;
        e = n + w + 2;
        stat = code;
        rdy = (n > 1) ? 1'($urandom_range(0, 1)) : 1'b1;
        for (int t = 1; t <= e; t++) begin
            @(posedge clk);
            @(negedge clk);
            if (t >= e) tag = "R7";
            else if (t < 2) tag = "R2";
            else if (t == 2) tag = "R2";
            else if (t > n + 1) tag = "R8";
            else if (glt && t <= n) tag = "R9";
            else if (code == 3'b011) tag = "R6";
            else if (code == 3'b010 || code == 3'b110) tag = "R4";
            else tag = "R3 R5";
            check(tag, obs(), exp_out(code, t, e));
            if (t + 1 <= n) begin
                stat = glt ? 3'($urandom_range(0, 6)) : code;
                rdy  = 1'($urandom_range(0, 1));
            end else begin
                stat = 3'b111;
                rdy  = (t + 1 <= n + w) ? 1'b0 : 1'b1;
            end
        end
        // idle gap with passive status
        for (int g = 0; g < 2; g++) begin
            @(posedge clk);
            @(negedge clk);
            check("R7", obs(), 8'b0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", obs(), 8'b0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", obs(), 8'b0);

        // directed corners
        run_cycle(3'b101, 1, 0, 1'b0);   // shortest read
        run_cycle(3'b110, 2, 0, 1'b0);   // write ending right after setup
        run_cycle(3'b100, 3, 0, 1'b0);   // code fetch gives memory read
        run_cycle(3'b000, 3, 1, 1'b0);   // acknowledge
        run_cycle(3'b001, 3, 4, 1'b0);   // io read held by rdy low
        run_cycle(3'b010, 4, 2, 1'b1);   // io write with glitches
        run_cycle(3'b011, 5, 1, 1'b1);   // halt
        run_cycle(3'b110, 6, 3, 1'b1);

        for (int i = 0; i < 300; i++) begin
            run_cycle(3'($urandom_range(0, 6)), int'($urandom_range(1, 6)),
                      int'($urandom_range(0, 4)), 1'($urandom_range(0, 1)));
        end

        // R1: reset in the middle of a command
        stat = 3'b101;
        for (int t = 1; t <= 4; t++) begin
            @(posedge clk);
            @(negedge clk);
        end
        check("R3", obs(), 8'b0100_0010);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", obs(), 8'b0);
        stat = 3'b111;
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", obs(), 8'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: cycles %0d expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule